// File: doc/BRIEF.md
# Pipelined Flash Byte Data Port

This block sits between a host register bus and a slow byte-wide flash I/O bus and moves data one byte per host access. A read burst is pipelined: the host first reads a priming register, which starts a flash byte fetch and returns nothing useful. Each following read of the data window returns the byte fetched by the access before it and starts the next fetch. The final byte is taken from a drain register, which hands over the held byte and starts no further fetch.

The data window covers a whole 256-address page. Every offset in that page reaches the same flash byte, so a host can step its address through the window as it walks a buffer. Writes to the window go out on the flash bus behind a write strobe. A write of zero to a terminate register waits for the pipe to empty and closes the burst. Two side registers complete the map. A no-operation register only consumes an access slot. A control register reports the flash ready line.

Every flash strobe lasts a fixed number of cycles. While the engine is busy, any host access that needs the pipe is held off with a wait signal. A read of the window or of the drain register with no priming read before it returns the stale pipeline byte and sets a sticky protocol-error flag.

Top module: `flash_data_port`

## Requirements
- R1: After reset, flashRe, flashWe, hostWait and protoErr are all low.
- R2: An accepted read of the priming register (INIT_ADDR, default 0x010) returns 0x00. It drives flashRe high for exactly STROBE_CYC cycles (default 3), starting in the cycle after acceptance, and the byte on flashDin in the last of those cycles is captured.
- R3: An accepted read of any address whose upper bits match WIN_BASE (default 0x800–0x8FF) in a primed pipe returns the last captured byte and starts the next fetch. The offset within the window does not matter.
- R4: An accepted read of the drain register (LAST_ADDR, default 0x011) returns the last captured byte, starts no fetch and leaves the pipe unprimed.
- R5: While a fetch or write strobe is in progress, host reads of the window, priming or drain register, window writes and zero writes to the terminate register are held with hostWait high until the engine is idle.
- R6: A window or drain read while the pipe is unprimed returns the stale captured byte, starts no fetch and sets protoErr.
- R7: An accepted window write drives flashDout with the written byte and holds flashWe high for STROBE_CYC cycles. A second window write issued straight after it waits STROBE_CYC cycles.
- R8: A write of 0x00 to the terminate register (TERM_ADDR, default 0x012) waits for the engine to go idle and then unprimes the pipe. A nonzero write there is accepted at once and has no effect.
- R9: A read of the no-operation register (NOP_ADDR, default 0x001) returns 0x00, never waits and changes no state.
- R10: A read of the control register (CTRL_ADDR, default 0x002) returns flashReady in bit 0, with all other bits zero.
- R11: protoErr stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | ADDR_W | Host register address |
| hostRd | input | 1 | Host read request, held while hostWait is high |
| hostWr | input | 1 | Host write request, held while hostWait is high |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Host read data, valid in the accepting cycle |
| hostWait | output | 1 | Holds the current host access |
| protoErr | output | 1 | Sticky unprimed-read error |
| flashDin | input | DATA_W | Byte from the flash I/O bus |
| flashDout | output | DATA_W | Byte to the flash I/O bus |
| flashRe | output | 1 | Flash read strobe |
| flashWe | output | 1 | Flash write strobe |
| flashReady | input | 1 | Flash ready/busy line |

## Verification
The main read path is tested with a full burst: a priming read, window reads at offsets 0x00, 0x01 and 0xFF, and a drain read. This shows whether data lags by exactly one access and whether the window offset is ignored. A nonzero terminate write is sent while a fetch is still in flight, and a zero terminate write is sent after it. Together they separate the wait-and-unprime effect of the zero write from the no-effect case, and the zero write sets up the unprimed read that must raise the error flag. Back-to-back window writes show whether the second write is held for a full strobe, and NOP and control reads confirm the side registers add no stall.

// File: rtl/flash_port_pkg.sv
package flash_port_pkg;
  typedef enum logic [1:0] {RD_ZERO, RD_PIPE, RD_CTRL} rdSel_e;

  typedef struct packed {
    logic   startWrite;
    logic   capture;
    rdSel_e rdSel;
  } portStrobes_t;
endpackage

// File: rtl/flash_port_ctrl.sv
module flash_port_ctrl
  import flash_port_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int WIN_SIZE = 256,
  parameter logic [ADDR_W-1:0] WIN_BASE = 12'h800,
  parameter logic [ADDR_W-1:0] NOP_ADDR = 12'h001,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h002,
  parameter logic [ADDR_W-1:0] INIT_ADDR = 12'h010,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 12'h011,
  parameter logic [ADDR_W-1:0] TERM_ADDR = 12'h012,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic              hostWait,
  output logic              protoErr,
  output logic              flashRe,
  output logic              flashWe,
  output portStrobes_t      strobes
);
  localparam int WIN_LSB = $clog2(WIN_SIZE);
  localparam int CNT_W = $clog2(STROBE_CYC) + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

  typedef enum logic [1:0] {ENG_IDLE, ENG_FETCH, ENG_WRITE} engState_e;

  engState_e engState;
  logic [CNT_W-1:0] strobeCnt;
  logic primed;
  logic errFlag;

  logic isWin, isInit, isLast, isTerm, isNop, isCtrl;
  logic busy, termZero, pipeAccess, startFetch, startWrite;

  assign isWin  = hostAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB];
  assign isInit = hostAddr == INIT_ADDR;
  assign isLast = hostAddr == LAST_ADDR;
  assign isTerm = hostAddr == TERM_ADDR;
  assign isNop  = hostAddr == NOP_ADDR;
  assign isCtrl = hostAddr == CTRL_ADDR;

  assign busy       = engState != ENG_IDLE;
  assign termZero   = hostWr && !hostRd && isTerm && (hostWdata == '0);
  assign pipeAccess = (hostRd && (isWin || isInit || isLast))
                    || (hostWr && !hostRd && isWin) || termZero;
  assign hostWait   = pipeAccess && busy;
  assign startFetch = !busy && hostRd && (isInit || (isWin && primed));
  assign startWrite = !busy && hostWr && !hostRd && isWin;

  assign flashRe  = engState == ENG_FETCH;
  assign flashWe  = engState == ENG_WRITE;
  assign protoErr = errFlag;

  always_comb begin
    strobes.startWrite = startWrite;
    strobes.capture    = (engState == ENG_FETCH) && (strobeCnt == '0);
    if (hostRd && (isWin || isLast) && !isNop)
      strobes.rdSel = RD_PIPE;
    else if (hostRd && isCtrl)
      strobes.rdSel = RD_CTRL;
    else
      strobes.rdSel = RD_ZERO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engState  <= ENG_IDLE;
      strobeCnt <= '0;
      primed    <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (!busy) begin
        if (startFetch) begin
          engState  <= ENG_FETCH;
          strobeCnt <= CNT_LOAD;
        end else if (startWrite) begin
          engState  <= ENG_WRITE;
          strobeCnt <= CNT_LOAD;
        end
        if (hostRd && isInit) primed <= 1'b1;
        if ((hostRd && isLast) || termZero) primed <= 1'b0;
        if (hostRd && (isWin || isLast) && !primed) errFlag <= 1'b1;
      end else if (strobeCnt == '0) begin
        engState <= ENG_IDLE;
      end else begin
        strobeCnt <= strobeCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_port_dp.sv
module flash_port_dp
  import flash_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strobes,
  input  logic [DATA_W-1:0] flashDin,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              flashReady,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] flashDout
);
  logic [DATA_W-1:0] pipeReg;
  logic [DATA_W-1:0] writeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeReg  <= '0;
      writeReg <= '0;
    end else begin
      if (strobes.capture) pipeReg <= flashDin;
      if (strobes.startWrite) writeReg <= hostWdata;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_PIPE: hostRdata = pipeReg;
      RD_CTRL: hostRdata = {{(DATA_W-1){1'b0}}, flashReady};
      default: hostRdata = '0;
    endcase
  end

  assign flashDout = writeReg;
endmodule

// File: rtl/flash_data_port.sv
module flash_data_port
  import flash_port_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int WIN_SIZE = 256,
  parameter logic [ADDR_W-1:0] WIN_BASE = 12'h800,
  parameter logic [ADDR_W-1:0] NOP_ADDR = 12'h001,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h002,
  parameter logic [ADDR_W-1:0] INIT_ADDR = 12'h010,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 12'h011,
  parameter logic [ADDR_W-1:0] TERM_ADDR = 12'h012,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostWait,
  output logic              protoErr,
  input  logic [DATA_W-1:0] flashDin,
  output logic [DATA_W-1:0] flashDout,
  output logic              flashRe,
  output logic              flashWe,
  input  logic              flashReady
);
  portStrobes_t strobes;

  flash_port_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_SIZE(WIN_SIZE), .WIN_BASE(WIN_BASE),
    .NOP_ADDR(NOP_ADDR), .CTRL_ADDR(CTRL_ADDR), .INIT_ADDR(INIT_ADDR),
    .LAST_ADDR(LAST_ADDR), .TERM_ADDR(TERM_ADDR), .STROBE_CYC(STROBE_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostWait(hostWait), .protoErr(protoErr),
    .flashRe(flashRe), .flashWe(flashWe), .strobes(strobes)
  );

  flash_port_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .flashDin(flashDin),
    .hostWdata(hostWdata), .flashReady(flashReady),
    .hostRdata(hostRdata), .flashDout(flashDout)
  );
endmodule

// File: rtl/flash_data_port_chk.sv
module flash_data_port_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int WIN_SIZE = 256,
  parameter logic [ADDR_W-1:0] WIN_BASE = 12'h800,
  parameter logic [ADDR_W-1:0] NOP_ADDR = 12'h001,
  parameter logic [ADDR_W-1:0] INIT_ADDR = 12'h010,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 12'h011
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostRd,
  input logic              hostWr,
  input logic [DATA_W-1:0] hostWdata,
  input logic              hostWait,
  input logic              protoErr,
  input logic [DATA_W-1:0] flashDout,
  input logic              flashRe,
  input logic              flashWe
);
  localparam int WIN_LSB = $clog2(WIN_SIZE);
  logic inWin;
  assign inWin = hostAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB];

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(flashRe && flashWe));
  assert_hold_during_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && inWin && (flashRe || flashWe)) |-> hostWait);
  assert_init_fetches_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == INIT_ADDR && !hostWait) |=> flashRe);
  assert_drain_no_fetch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == LAST_ADDR && !hostWait) |=> !flashRe);
  assert_write_drives_bus_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostRd && inWin && !hostWait) |=> (flashWe && flashDout == $past(hostWdata)));
  assert_nop_never_waits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == NOP_ADDR) |-> !hostWait);
  assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

bind flash_data_port flash_data_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_SIZE(WIN_SIZE), .WIN_BASE(WIN_BASE),
  .NOP_ADDR(NOP_ADDR), .INIT_ADDR(INIT_ADDR), .LAST_ADDR(LAST_ADDR)
) uChk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
  .hostWdata(hostWdata), .hostWait(hostWait), .protoErr(protoErr),
  .flashDout(flashDout), .flashRe(flashRe), .flashWe(flashWe)
);

// File: tb/sim_flash_data_port.sv
`timescale 1ns/1ps
module sim_flash_data_port;
  localparam int S = 3;
  localparam logic [11:0] WIN = 12'h800, NOPA = 12'h001, CTRLA = 12'h002,
                          INITA = 12'h010, LASTA = 12'h011, TERMA = 12'h012;

  logic clk = 0, rstN = 0;
  logic [11:0] hostAddr = '0;
  logic hostRd = 0, hostWr = 0, flashReady = 1;
  logic [7:0] hostWdata = '0, flashDin = '0;
  logic [7:0] hostRdata, flashDout;
  logic hostWait, protoErr, flashRe, flashWe;

  int errors = 0, checks = 0, cycles = 0;
  bit live = 0;

  // behavioural reference state
  int mLeft = 0, mMode = 0, mFetchCnt = 0;
  bit mPrimed = 0, mErr = 0;
  logic [7:0] mPipe = 0, mWr = 0;

  always #4 clk = ~clk;

  flash_data_port u0 (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostWait(hostWait),
    .protoErr(protoErr), .flashDin(flashDin), .flashDout(flashDout),
    .flashRe(flashRe), .flashWe(flashWe), .flashReady(flashReady)
  );

  function automatic logic [7:0] fbyte(int k);
    return 8'h5A + 8'(k * 29);
  endfunction

  function automatic bit inWin(logic [11:0] a);
    return a[11:8] == WIN[11:8];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) flashDin <= fbyte(mFetchCnt);

  // reference model update
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mLeft = 0; mMode = 0; mPrimed = 0; mErr = 0; mPipe = 0; mWr = 0;
    end else if (mLeft > 0) begin
      mLeft--;
      if (mLeft == 0 && mMode == 0) begin
        mPipe = flashDin;
        mFetchCnt++;
      end
    end else begin
      if (hostRd && (inWin(hostAddr) || hostAddr == LASTA) && !mPrimed) mErr = 1;
      if (hostRd && (hostAddr == INITA || (inWin(hostAddr) && mPrimed))) begin
        mLeft = S; mMode = 0;
      end else if (hostWr && !hostRd && inWin(hostAddr)) begin
        mLeft = S; mMode = 1; mWr = hostWdata;
      end
      if (hostRd && hostAddr == INITA) mPrimed = 1;
      if ((hostRd && hostAddr == LASTA) ||
          (hostWr && !hostRd && hostAddr == TERMA && hostWdata == 0)) mPrimed = 0;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (live) begin
      bit busy, acc, expWait;
      logic [7:0] expRd;
      busy = mLeft > 0;
      acc = (hostRd && (inWin(hostAddr) || hostAddr == INITA || hostAddr == LASTA))
         || (hostWr && !hostRd && inWin(hostAddr))
         || (hostWr && !hostRd && hostAddr == TERMA && hostWdata == 0);
      expWait = acc && busy;
      chk(hostWait == expWait, "R5 hostWait", hostWait, expWait);
      chk(flashRe == (busy && mMode == 0), "R2 flashRe", flashRe, busy && mMode == 0);
      chk(flashWe == (busy && mMode == 1), "R7 flashWe", flashWe, busy && mMode == 1);
      if (busy && mMode == 1) chk(flashDout == mWr, "R7 flashDout", flashDout, mWr);
      chk(protoErr == mErr, "R6 protoErr", protoErr, mErr);
      if (hostRd && !expWait) begin
        if (inWin(hostAddr) || hostAddr == LASTA) expRd = mPipe;
        else if (hostAddr == CTRLA) expRd = {7'b0, flashReady};
        else expRd = 8'h00;
        chk(hostRdata == expRd, "R3 hostRdata", hostRdata, expRd);
      end
    end
  end

  task automatic rd(input logic [11:0] a, output logic [7:0] d, output int waited);
    bit done = 0;
    waited = 0;
    hostAddr = a; hostRd = 1;
    while (!done) begin
      @(negedge clk);
      if (!hostWait) begin d = hostRdata; done = 1; end
      else waited++;
      @(posedge clk); #1;
    end
    hostRd = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] v, output int waited);
    bit done = 0;
    waited = 0;
    hostAddr = a; hostWr = 1; hostWdata = v;
    while (!done) begin
      @(negedge clk);
      if (!hostWait) done = 1; else waited++;
      @(posedge clk); #1;
    end
    hostWr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int w, base, reCount;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(!flashRe && !flashWe && !hostWait && !protoErr, "R1 reset outputs",
        {flashRe, flashWe, hostWait, protoErr}, 0);
    live = 1;
    @(posedge clk); #1;

    // R9 / R10 side registers
    rd(NOPA, d, w);  chk(d == 0 && w == 0, "R9 nop read", {w, d}, 0);
    rd(CTRLA, d, w); chk(d == 8'h01, "R10 ctrl ready", d, 8'h01);
    flashReady = 0;
    rd(CTRLA, d, w); chk(d == 8'h00, "R10 ctrl busy", d, 8'h00);
    flashReady = 1;

    // R2/R3/R4 burst of four bytes
    base = mFetchCnt;
    rd(INITA, d, w); chk(d == 8'h00, "R2 init data", d, 0);
    rd(WIN + 12'h000, d, w);
    chk(w == S, "R5 wait after init", w, S);
    chk(d == fbyte(base), "R3 byte0", d, fbyte(base));
    rd(NOPA, d, w);  chk(w == 0, "R9 nop during fetch", w, 0);
    rd(WIN + 12'h001, d, w); chk(d == fbyte(base + 1), "R3 byte1", d, fbyte(base + 1));
    rd(WIN + 12'h0FF, d, w); chk(d == fbyte(base + 2), "R3 byte2 top offset", d, fbyte(base + 2));
    rd(LASTA, d, w); chk(d == fbyte(base + 3), "R4 last byte", d, fbyte(base + 3));
    reCount = 0;
    repeat (2 * S) begin @(negedge clk); if (flashRe) reCount++; end
    chk(reCount == 0, "R4 no fetch after drain", reCount, 0);
    @(posedge clk); #1;

    // R8 nonzero terminate ignored, even mid-fetch
    base = mFetchCnt;
    rd(INITA, d, w);
    rd(WIN + 12'h010, d, w);
    wr(TERMA, 8'h55, w); chk(w == 0, "R8 nonzero term no wait", w, 0);
    rd(WIN + 12'h011, d, w);
    chk(d == fbyte(base + 1), "R8 pipe still primed", d, fbyte(base + 1));
    chk(protoErr == 0, "R8 no error after nonzero term", protoErr, 0);
    // R8 zero terminate waits for drain and unprimes
    wr(TERMA, 8'h00, w); chk(w > 0, "R8 zero term waits", w, 1);
    idle(1);
    rd(WIN + 12'h020, d, w);
    chk(d == fbyte(base + 2), "R6 stale byte", d, fbyte(base + 2));
    @(negedge clk);
    chk(protoErr == 1, "R6 error raised", protoErr, 1);
    chk(!flashRe, "R6 no fetch", flashRe, 0);
    @(posedge clk); #1;

    // R7 back-to-back writes
    wr(WIN + 12'h000, 8'hC3, w); chk(w == 0, "R7 first write", w, 0);
    wr(WIN + 12'h001, 8'h3C, w); chk(w == S, "R7 second write held", w, S);
    @(negedge clk);
    chk(flashWe && flashDout == 8'h3C, "R7 second byte on bus", flashDout, 8'h3C);
    @(posedge clk); #1;
    idle(2 * S);
    chk(protoErr == 1, "R11 error sticky", protoErr, 1);
    rd(NOPA, d, w);
    chk(protoErr == 1, "R11 still sticky", protoErr, 1);
    idle(2);
    finish_run();
  end
endmodule